// File: doc/BRIEF.md
# Reloadable-Period PWM Generator

This block drives one pulse-width-modulated output from the system clock. A period counter counts upward. When it reaches its all-ones value, it does not wrap to zero: it restarts from a programmable start value. That start value sets the output frequency. The counter is compared each cycle with a threshold register. The output is high while the counter is strictly above the threshold.

An optional prescaler stage slows the period counter. The prescaler is a second counter with its own start value. It sends one enable pulse each time it reaches its all-ones value. With the prescaler, the frequency can change while the period start value stays at zero, which keeps the full duty resolution.

Software changes the three settings through a plain parallel write port: a strobe, a 2-bit select and a data word. Each written value first goes to a holding copy. The value in use is updated only at a boundary, so a change never cuts a period short.

Top module: `pwm_reload_gen`

## Requirements
- R1: The period counter advances by one on each enabled clock. When it is all-ones on an enabled clock, it loads the active period start value instead of zero. One output period is therefore (2^CNT_W − start) enabled clocks.
- R2: The output is registered. In every cycle it is high exactly when the period counter value is strictly greater than the active threshold, and low otherwise. It changes on the same clock edge as the counter.
- R3: A threshold of all-ones (the counter maximum) keeps the output low in every cycle. A threshold below the active period start value keeps it high in every cycle. In both cases the output has no rising edge.
- R4: A write takes place when wr_en is high at a clock edge. The wr_sel code picks the target: 0 writes the period start value, 1 writes the threshold, 2 writes the prescaler start value. Code 3 changes nothing that the output can show.
- R5: A written period start value or threshold waits in a holding copy. It becomes active only on the enabled clock where the period counter is all-ones. A period already in progress finishes with its old values.
- R6: The prescaler counts every clock. At its all-ones value it reloads its own active start value and emits a one-clock enable. With prescaler start p, the period counter is enabled once every (2^PRE_W − p) clocks; when p is all-ones, it is enabled every clock. A written prescaler start value becomes active when the prescaler next reloads.
- R7: rst is synchronous and active high. While rst is asserted, and on the first cycle after it is released, the output is low. Reset sets the period start and the threshold to 0 and the prescaler start to all-ones, and loads each counter with its start value. So in the first cycle after release, the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the setting registers |
| wr_sel | input | 2 | Write target: 0 period start, 1 threshold, 2 prescaler start, 3 none |
| wr_data | input | DATA_W | Value written; the low CNT_W or PRE_W bits are used |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
The bench builds the block with CNT_W = 4, PRE_W = 3 and the prescaler present. With these values a full-resolution period lasts 16 counts and the division factor runs from 1 to 8, so the longest period is 128 clocks. This makes every reload, both constant-output threshold cases, the slowest prescaler setting and a write that lands in the middle of a period reachable within a few hundred cycles each. The duty cycle is measured by counting high samples and rising edges over a whole number of periods, so the result does not depend on where the window starts.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

   // Target codes on the write select bus
   typedef enum logic [1:0] {
      SEL_PERIOD   = 2'd0,
      SEL_MARK     = 2'd1,
      SEL_PRESCALE = 2'd2,
      SEL_NONE     = 2'd3
   } pwm_sel_e;

   function automatic int max_w(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwm_shadow_reg.sv
// Holding copy plus active copy; the active copy loads only on commit.
module pwm_shadow_reg #(
   parameter int          W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         commit,
   output logic [W-1:0] act_q,
   output logic [W-1:0] act_d
);

   logic [W-1:0] hold_q;
   logic [W-1:0] hold_d;

   assign hold_d = wr_en  ? wr_data : hold_q;
   assign act_d  = commit ? hold_d  : act_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= RST_VAL;
         act_q  <= RST_VAL;
      end else begin
         hold_q <= hold_d;
         act_q  <= act_d;
      end
   end

endmodule

// File: rtl/pwm_prescaler.sv
// Clock-enable divider that reloads from its own start value at all-ones.
module pwm_prescaler #(
   parameter int PRE_W   = 8,
   parameter bit USE_PRE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [PRE_W-1:0] wr_data,
   output logic             tick,
   output logic [PRE_W-1:0] ppre_act
);

   localparam logic [PRE_W-1:0] PMAX = '1;

   if (USE_PRE) begin : g_div
      logic [PRE_W-1:0] pcnt_q;
      logic [PRE_W-1:0] ppre_d;

      assign tick = (pcnt_q == PMAX);

      pwm_shadow_reg #(
         .W      (PRE_W),
         .RST_VAL(PMAX)
      ) u_pre_reg (
         .clk    (clk),
         .rst    (rst),
         .wr_en  (wr_en),
         .wr_data(wr_data),
         .commit (tick),
         .act_q  (ppre_act),
         .act_d  (ppre_d)
      );

      always_ff @(posedge clk) begin
         if (rst)       pcnt_q <= PMAX;
         else if (tick) pcnt_q <= ppre_d;
         else           pcnt_q <= pcnt_q + 1'b1;
      end
   end else begin : g_bypass
      logic unused_pre;
      assign unused_pre = ^{clk, rst, wr_en, wr_data};
      assign tick       = 1'b1;
      assign ppre_act   = PMAX;
   end

endmodule

// File: rtl/pwm_period_ctr.sv
// Period counter: steps on enable, restarts from the start value after all-ones.
module pwm_period_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] start_d,
   output logic             wrap,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_d
);

   localparam logic [CNT_W-1:0] CMAX = '1;

   assign wrap = en && (cnt_q == CMAX);

   always_comb begin
      if (wrap)    cnt_d = start_d;
      else if (en) cnt_d = cnt_q + 1'b1;
      else         cnt_d = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

endmodule

// File: rtl/pwm_reload_gen.sv
module pwm_reload_gen
   import pwm_reload_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int PRE_W         = 8,
   parameter bit USE_PRESCALER = 1'b1,
   localparam int DATA_W       = max_w(CNT_W, PRE_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pwm_out
);

   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt_w
      $error("pwm_reload_gen: CNT_W must be within 2..31");
   end
   if (PRE_W < 1 || PRE_W > 31) begin : g_bad_pre_w
      $error("pwm_reload_gen: PRE_W must be within 1..31");
   end

   logic             wr_period;
   logic             wr_mark;
   logic             wr_pre;
   logic             cnt_en;
   logic             wrap;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] per_act;
   logic [CNT_W-1:0] per_d;
   logic [CNT_W-1:0] mark_act;
   logic [CNT_W-1:0] mark_d;
   logic [PRE_W-1:0] ppre_act;
   logic             unused_data;

   assign wr_period   = wr_en && (wr_sel == SEL_PERIOD);
   assign wr_mark     = wr_en && (wr_sel == SEL_MARK);
   assign wr_pre      = wr_en && (wr_sel == SEL_PRESCALE);
   assign unused_data = ^wr_data;

   pwm_prescaler #(
      .PRE_W  (PRE_W),
      .USE_PRE(USE_PRESCALER)
   ) u_prescaler (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_pre),
      .wr_data (wr_data[PRE_W-1:0]),
      .tick    (cnt_en),
      .ppre_act(ppre_act)
   );

   pwm_shadow_reg #(
      .W      (CNT_W),
      .RST_VAL('0)
   ) u_period_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_period),
      .wr_data(wr_data[CNT_W-1:0]),
      .commit (wrap),
      .act_q  (per_act),
      .act_d  (per_d)
   );

   pwm_shadow_reg #(
      .W      (CNT_W),
      .RST_VAL('0)
   ) u_mark_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_mark),
      .wr_data(wr_data[CNT_W-1:0]),
      .commit (wrap),
      .act_q  (mark_act),
      .act_d  (mark_d)
   );

   pwm_period_ctr #(
      .CNT_W(CNT_W)
   ) u_period_ctr (
      .clk    (clk),
      .rst    (rst),
      .en     (cnt_en),
      .start_d(per_d),
      .wrap   (wrap),
      .cnt_q  (cnt_q),
      .cnt_d  (cnt_d)
   );

   // Compare next-state values so the registered output lines up with cnt_q
   always_ff @(posedge clk) begin
      if (rst) pwm_out <= 1'b0;
      else     pwm_out <= (cnt_d > mark_d);
   end

endmodule

// File: rtl/pwm_reload_chk.sv
module pwm_reload_chk #(
   parameter int CNT_W = 8,
   parameter int PRE_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] per_act,
   input logic [CNT_W-1:0] mark_act,
   input logic [PRE_W-1:0] ppre_act,
   input logic             tick,
   input logic             pwm_out
);

   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [PRE_W-1:0] PMAX = '1;

   // R1: step by one on enable below all-ones
   assert_step_R1: assert property (@(posedge clk) disable iff (rst)
      (tick && cnt_q != CMAX) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R1: restart from the active start value after all-ones
   assert_reload_R1: assert property (@(posedge clk) disable iff (rst)
      (tick && cnt_q == CMAX) |=> (cnt_q == per_act));

   // R1: no enable, no movement
   assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_q));

   // R2: output follows the strict comparison
   assert_compare_R2: assert property (@(posedge clk) disable iff (rst)
      pwm_out == (cnt_q > mark_act));

   // R3: constant cases
   assert_const_low_R3: assert property (@(posedge clk) disable iff (rst)
      (mark_act == CMAX) |-> !pwm_out);
   assert_const_high_R3: assert property (@(posedge clk) disable iff (rst)
      (mark_act < per_act) |-> pwm_out);

   // R5: active values move only at the reload point
   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !(tick && cnt_q == CMAX) |=> ($stable(per_act) && $stable(mark_act)));

   // R6: a start value of all-ones enables every clock
   assert_every_clk_R6: assert property (@(posedge clk) disable iff (rst)
      (ppre_act == PMAX) |-> tick);

   // R7: reset leaves the output low and the counter at its start value
   assert_reset_R7: assert property (@(posedge clk)
      rst |=> (!pwm_out && cnt_q == per_act));

endmodule

bind pwm_reload_gen pwm_reload_chk #(
   .CNT_W(CNT_W),
   .PRE_W(PRE_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .cnt_q   (cnt_q),
   .per_act (per_act),
   .mark_act(mark_act),
   .ppre_act(ppre_act),
   .tick    (cnt_en),
   .pwm_out (pwm_out)
);

// File: tb/tb_pwm_reload_gen.sv
module tb_pwm_reload_gen;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 4;
   localparam int PRE_W      = 3;
   localparam int DATA_W     = 4;
   localparam int NVEC       = 8;

   // columns: period start, threshold, prescaler start, period clocks, high clocks
   localparam int VEC [NVEC][5] = '{
      '{0,  7, 7,  16,  8},
      '{0,  0, 7,  16, 15},
      '{8, 11, 7,   8,  4},
      '{8,  3, 7,   8,  8},
      '{0, 15, 7,  16,  0},
      '{4,  9, 5,  36, 18},
      '{0, 14, 0, 128,  8},
      '{14,14, 7,   2,  1}
   };
   localparam string TAG [NVEC] = '{"R2", "R2", "R1", "R3", "R3", "R6", "R6", "R1"};

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_sel = 2'd0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              pwm_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   pwm_reload_gen #(
      .CNT_W        (CNT_W),
      .PRE_W        (PRE_W),
      .USE_PRESCALER(1'b1)
   ) dut (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .pwm_out(pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] sel, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic measure(input int n, output int hi, output int rises);
      logic prev;
      hi    = 0;
      rises = 0;
      prev  = pwm_out;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out) hi++;
         if (pwm_out && !prev) rises++;
         prev = pwm_out;
      end
   endtask

   initial begin
      int hi;
      int rises;
      int run;
      logic prev;
      logic seen;

      // R7: held in reset, output low
      repeat (3) @(negedge clk);
      check("R7 output during reset", int'(pwm_out), 0);
      rst = 1'b0;
      check("R7 output at release", int'(pwm_out), 0);
      @(negedge clk);
      check("R7 first count after release", int'(pwm_out), 1);

      // Table walk
      for (int v = 0; v < NVEC; v++) begin
         write_reg(2'd2, DATA_W'(VEC[v][2]));
         write_reg(2'd0, DATA_W'(VEC[v][0]));
         write_reg(2'd1, DATA_W'(VEC[v][1]));
         repeat (400) @(negedge clk);
         measure(3 * VEC[v][3], hi, rises);
         check({TAG[v], " high clocks"}, hi, 3 * VEC[v][4]);
         check({TAG[v], " rising edges"}, rises,
               (VEC[v][4] == 0 || VEC[v][4] == VEC[v][3]) ? 0 : 3);
      end

      // R5: threshold written mid-period applies only after the reload
      write_reg(2'd2, 4'd7);
      write_reg(2'd0, 4'd0);
      write_reg(2'd1, 4'd7);
      repeat (400) @(negedge clk);
      prev = pwm_out;
      seen = 1'b0;
      while (!seen) begin
         @(negedge clk);
         seen = pwm_out && !prev;
         prev = pwm_out;
      end
      wr_en   = 1'b1;
      wr_sel  = 2'd1;
      wr_data = 4'd3;
      run     = 1;
      @(negedge clk);
      wr_en = 1'b0;
      while (pwm_out) begin
         run++;
         @(negedge clk);
      end
      check("R5 current high run keeps old threshold", run, 8);
      run = 0;
      while (!pwm_out) begin
         run++;
         @(negedge clk);
      end
      check("R5 low run after reload uses new threshold", run, 4);
      run = 0;
      while (pwm_out) begin
         run++;
         @(negedge clk);
      end
      check("R4 high run with threshold 3", run, 12);

      // R4: select code 3 has no effect
      write_reg(2'd3, 4'hE);
      repeat (200) @(negedge clk);
      measure(48, hi, rises);
      check("R4 code 3 ignored high clocks", hi, 36);
      check("R4 code 3 ignored rising edges", rises, 3);

      // R7: reset mid-run restores defaults
      write_reg(2'd2, 4'd2);
      repeat (50) @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 output low in mid-run reset", int'(pwm_out), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R7 counting restarts after reset", int'(pwm_out), 1);
      measure(32, hi, rises);
      check("R7 default settings high clocks", hi, 30);
      check("R7 default settings rising edges", rises, 2);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule